// File: doc/BRIEF.md
# Hashed Ownership Record Table

This block keeps a table of ownership records for a hybrid transactional memory. Software transactions take and drop ownership of records with acquire-read, acquire-write and release requests. Each request carries an address and a transaction id. Every address is folded by XOR into a record index, so unrelated addresses can share one record. Each record is free, shared by one or more readers with a reader count, or held exclusively by one writer.

Best-effort hardware transactions use a separate check port. A check asks whether a read or a write to an address is compatible with the current software owners. A checked record is added to the watch mask of the hardware transaction slot that asked. Any granted change to a watched record later raises that slot's fail flag, even when the change cannot truly conflict, such as a move from free to shared. A counter of active software transactions lets checks succeed at once, without reading the table, while no software transaction is running.

Top module: `orec_guard`

## Requirements
- R1: The record index is the XOR of the address cut into 6-bit chunks from bit 0 upward, with the top chunk zero-padded. Addresses with equal index share one record.
- R2: Acquire-read (op code 0) is granted on a free record, which then becomes shared with one reader. It is also granted on a shared record, and adds one reader. It is refused on an exclusive record.
- R3: Acquire-write (op code 1) is granted on a free record, which becomes exclusive to the requesting id. It is refused on an exclusive record, and on a shared record that does not meet R4.
- R4: Acquire-write on a shared record with exactly one reader is granted, and upgrades the record to exclusive, when the requester is the id that first took the record from free and has not released it since.
- R5: Release (op code 2) on an exclusive record is granted only for the owning id, and frees the record. On a shared record it is granted and removes one reader; removing the last reader frees the record. On a free record it is refused, with no change. Op code 3 is always refused.
- R6: The reader count saturates at 63. An acquire-read on a record that already has 63 readers is refused.
- R7: With active software transactions present, a write check (chk_write=1) is compatible only with a free record. A read check is compatible with any record that is not exclusive.
- R8: While the active software count is zero, every check reports compatible, and the checked record is not added to the watch mask.
- R9: The active software count rises on sw_inc and falls on sw_dec. It is unchanged when both are high together, and stays at zero on sw_dec at zero.
- R10: A granted request to a record in a slot's watch mask sets that slot's hw_fail bit, which stays set. hw_begin clears that slot's watch mask and fail bit.
- R11: Each request gets rsp_valid with rsp_grant on the next cycle. Each check gets chk_done with chk_ok on the next cycle. At most one request and one check are taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Software request present |
| req_op | input | 2 | 0 acquire-read, 1 acquire-write, 2 release, 3 none |
| req_addr | input | 16 | Request address |
| req_tid | input | 4 | Requesting software transaction id |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_grant | output | 1 | 1 granted, 0 refused |
| chk_valid | input | 1 | Hardware check present |
| chk_write | input | 1 | 1 write access, 0 read access |
| chk_addr | input | 16 | Checked address |
| chk_hw | input | 2 | Hardware transaction slot |
| chk_done | output | 1 | Result for the check of the previous cycle |
| chk_ok | output | 1 | 1 compatible |
| hw_begin | input | 1 | Start a hardware transaction in a slot |
| hw_begin_id | input | 2 | Slot being started |
| hw_fail | output | 4 | Per-slot fail flags |
| sw_inc | input | 1 | A software transaction starts |
| sw_dec | input | 1 | A software transaction ends |

## Verification
The bench targets the spurious failure first: a move from free to shared on a record that a slot has checked must raise hw_fail. A design that watched only for writes would leave the flag low. Aliasing is tested with three addresses that fold to one index. A wrong fold would let a reader in beside a writer. The upgrade rule is tested both ways. A design that only counted readers would let a second reader upgrade, or would block the sole reader. The bench also drives the reader count to saturation, where a wrapping counter would grant the 64th reader and lose the record. It drives the software count through a decrement at zero and a simultaneous increment and decrement. There, an underflowing counter would disable the short-circuit.

// File: rtl/orec_pkg.sv
package orec_pkg;
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_SHARED = 2'd1,
        ST_EXCL   = 2'd2
    } own_e;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_REL  = 2'd2,
        OP_NONE = 2'd3
    } op_e;
endpackage

// File: rtl/orec_hash.sv
module orec_hash #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int N_CHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W   = N_CHUNK * IDX_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[ADDR_W-1:0] = addr;
        idx = '0;
        for (int c = 0; c < N_CHUNK; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/orec_table.sv
module orec_table
    import orec_pkg::*;
#(
    parameter int N_REC = 64,
    parameter int IDX_W = 6,
    parameter int CNT_W = 6,
    parameter int TID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  op_e              req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [TID_W-1:0] req_tid,
    input  logic [IDX_W-1:0] chk_idx,
    output own_e             chk_state,
    output logic             upd_fire,
    output logic [IDX_W-1:0] upd_idx,
    output logic             rsp_valid,
    output logic             rsp_grant
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        own_e             st;
        logic [CNT_W-1:0] cnt;
        logic [TID_W-1:0] tid;
        logic             sole;
    } rec_t;

    typedef struct packed {
        rec_t [N_REC-1:0] tbl;
        logic             rsp_v;
        logic             rsp_g;
    } tbl_t;

    localparam rec_t REC_FREE = '{st: ST_FREE, cnt: '0, tid: '0, sole: 1'b0};

    tbl_t s_d, s_q;
    rec_t cur, nxt;
    logic grant;

    always_comb begin
        s_d   = s_q;
        cur   = s_q.tbl[req_idx];
        nxt   = cur;
        grant = 1'b0;
        if (req_valid) begin
            case (req_op)
                OP_RD: begin
                    if (cur.st == ST_FREE) begin
                        nxt   = '{st: ST_SHARED, cnt: CNT_ONE, tid: req_tid, sole: 1'b1};
                        grant = 1'b1;
                    end else if (cur.st == ST_SHARED && cur.cnt != CNT_MAX) begin
                        nxt.cnt = cur.cnt + CNT_ONE;
                        grant   = 1'b1;
                    end
                end
                OP_WR: begin
                    if (cur.st == ST_FREE ||
                        (cur.st == ST_SHARED && cur.cnt == CNT_ONE &&
                         cur.sole && cur.tid == req_tid)) begin
                        nxt   = '{st: ST_EXCL, cnt: '0, tid: req_tid, sole: 1'b0};
                        grant = 1'b1;
                    end
                end
                OP_REL: begin
                    if (cur.st == ST_EXCL && cur.tid == req_tid) begin
                        nxt   = REC_FREE;
                        grant = 1'b1;
                    end else if (cur.st == ST_SHARED) begin
                        grant = 1'b1;
                        if (cur.cnt == CNT_ONE) begin
                            nxt = REC_FREE;
                        end else begin
                            nxt.cnt = cur.cnt - CNT_ONE;
                            if (cur.tid == req_tid) nxt.sole = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (grant) s_d.tbl[req_idx] = nxt;
        s_d.rsp_v = req_valid;
        s_d.rsp_g = grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tbl   <= {N_REC{REC_FREE}};
            s_q.rsp_v <= 1'b0;
            s_q.rsp_g <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chk_state = s_q.tbl[chk_idx].st;
    assign upd_fire  = grant;
    assign upd_idx   = req_idx;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_grant = s_q.rsp_g;
endmodule

// File: rtl/orec_watch.sv
module orec_watch #(
    parameter int N_HW  = 4,
    parameter int HW_W  = 2,
    parameter int N_REC = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_v,
    input  logic [HW_W-1:0]  begin_id,
    input  logic             add_v,
    input  logic [HW_W-1:0]  add_id,
    input  logic [IDX_W-1:0] add_idx,
    input  logic             upd_fire,
    input  logic [IDX_W-1:0] upd_idx,
    output logic [N_HW-1:0]  fail
);
    typedef struct packed {
        logic [N_HW-1:0][N_REC-1:0] watch;
        logic [N_HW-1:0]            fail;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        for (int h = 0; h < N_HW; h++) begin
            if (begin_v && begin_id == HW_W'(h)) begin
                w_d.watch[h] = '0;
                w_d.fail[h]  = 1'b0;
            end
            if (add_v && add_id == HW_W'(h)) w_d.watch[h][add_idx] = 1'b1;
            if (upd_fire && w_d.watch[h][upd_idx]) w_d.fail[h] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign fail = w_q.fail;
endmodule

// File: rtl/orec_guard.sv
module orec_guard
    import orec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int N_REC  = 64,
    parameter int CNT_W  = 6,
    parameter int TID_W  = 4,
    parameter int N_HW   = 4,
    parameter int SW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TID_W-1:0]  req_tid,
    output logic              rsp_valid,
    output logic              rsp_grant,
    input  logic              chk_valid,
    input  logic              chk_write,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [$clog2(N_HW)-1:0] chk_hw,
    output logic              chk_done,
    output logic              chk_ok,
    input  logic              hw_begin,
    input  logic [$clog2(N_HW)-1:0] hw_begin_id,
    output logic [N_HW-1:0]   hw_fail,
    input  logic              sw_inc,
    input  logic              sw_dec
);
    localparam int IDX_W = $clog2(N_REC);
    localparam int HW_W  = $clog2(N_HW);
    localparam logic [SW_W-1:0] SW_MAX = {SW_W{1'b1}};

    typedef struct packed {
        logic [SW_W-1:0] sw_cnt;
        logic            chk_v;
        logic            chk_r;
    } top_t;

    top_t t_d, t_q;
    logic [IDX_W-1:0] req_idx, chk_idx, upd_idx;
    own_e             chk_state;
    logic             upd_fire;
    logic             sw_idle;
    logic [SW_W-1:0]  sw_cnt_q;

    orec_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_req (.addr(req_addr), .idx(req_idx));
    orec_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_chk (.addr(chk_addr), .idx(chk_idx));

    orec_table #(.N_REC(N_REC), .IDX_W(IDX_W), .CNT_W(CNT_W), .TID_W(TID_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(op_e'(req_op)), .req_idx(req_idx), .req_tid(req_tid),
        .chk_idx(chk_idx), .chk_state(chk_state),
        .upd_fire(upd_fire), .upd_idx(upd_idx),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
    );

    orec_watch #(.N_HW(N_HW), .HW_W(HW_W), .N_REC(N_REC), .IDX_W(IDX_W)) u_watch (
        .clk(clk), .rst_n(rst_n),
        .begin_v(hw_begin), .begin_id(hw_begin_id),
        .add_v(chk_valid && !sw_idle), .add_id(chk_hw), .add_idx(chk_idx),
        .upd_fire(upd_fire), .upd_idx(upd_idx),
        .fail(hw_fail)
    );

    assign sw_idle = (t_q.sw_cnt == '0);

    always_comb begin
        t_d = t_q;
        if (sw_inc && !sw_dec && t_q.sw_cnt != SW_MAX) t_d.sw_cnt = t_q.sw_cnt + 1'b1;
        if (sw_dec && !sw_inc && !sw_idle)             t_d.sw_cnt = t_q.sw_cnt - 1'b1;
        t_d.chk_v = chk_valid;
        if (sw_idle)        t_d.chk_r = 1'b1;
        else if (chk_write) t_d.chk_r = (chk_state == ST_FREE);
        else                t_d.chk_r = (chk_state != ST_EXCL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign chk_done = t_q.chk_v;
    assign chk_ok   = t_q.chk_r;
    assign sw_cnt_q = t_q.sw_cnt;
endmodule

// File: rtl/orec_guard_chk.sv
module orec_guard_chk #(
    parameter int N_HW = 4,
    parameter int HW_W = 2,
    parameter int SW_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            chk_valid,
    input logic            chk_done,
    input logic            chk_ok,
    input logic            hw_begin,
    input logic [HW_W-1:0] hw_begin_id,
    input logic [N_HW-1:0] hw_fail,
    input logic            sw_inc,
    input logic            sw_dec,
    input logic [SW_W-1:0] sw_cnt
);
    logic [N_HW-1:0] beg_mask;
    assign beg_mask = hw_begin ? (N_HW'(1) << hw_begin_id) : '0;

    p_rsp_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

    p_chk_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chk_done == $past(chk_valid)));

    p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && sw_cnt == '0) |=> chk_ok);

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_inc == sw_dec) |=> $stable(sw_cnt));

    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(hw_fail) & ~$past(beg_mask)) & ~hw_fail) == '0));

    p_begin_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_begin && !req_valid) |=> ((hw_fail & $past(beg_mask)) == '0));
endmodule

bind orec_guard orec_guard_chk #(.N_HW(N_HW), .HW_W(HW_W), .SW_W(SW_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .rsp_valid(rsp_valid),
    .chk_valid(chk_valid), .chk_done(chk_done), .chk_ok(chk_ok),
    .hw_begin(hw_begin), .hw_begin_id(hw_begin_id), .hw_fail(hw_fail),
    .sw_inc(sw_inc), .sw_dec(sw_dec), .sw_cnt(sw_cnt_q)
);

// File: tb/orec_guard_test.sv
module orec_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_tid = '0;
    logic        rsp_valid, rsp_grant;
    logic        chk_valid = 1'b0;
    logic        chk_write = 1'b0;
    logic [15:0] chk_addr = '0;
    logic [1:0]  chk_hw = '0;
    logic        chk_done, chk_ok;
    logic        hw_begin = 1'b0;
    logic [1:0]  hw_begin_id = '0;
    logic [3:0]  hw_fail;
    logic        sw_inc = 1'b0;
    logic        sw_dec = 1'b0;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    always #10 clk = ~clk;

    orec_guard uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_tid(req_tid),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .chk_valid(chk_valid), .chk_write(chk_write), .chk_addr(chk_addr), .chk_hw(chk_hw),
        .chk_done(chk_done), .chk_ok(chk_ok),
        .hw_begin(hw_begin), .hw_begin_id(hw_begin_id), .hw_fail(hw_fail),
        .sw_inc(sw_inc), .sw_dec(sw_dec)
    );

    function automatic logic [5:0] fold(input logic [15:0] a);
        return a[5:0] ^ a[11:6] ^ {2'b00, a[15:12]};
    endfunction

    task automatic expect_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [3:0] t,
                          output logic g);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_tid = t;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3;
        g = rsp_grant;
    endtask

    task automatic req_exp(input string tag, input logic [1:0] op, input logic [15:0] a,
                           input logic [3:0] t, input logic exp);
        logic g;
        do_req(op, a, t, g);
        expect_eq(tag, int'(g), int'(exp));
    endtask

    task automatic chk_exp(input string tag, input logic [1:0] hw, input logic wr,
                           input logic [15:0] a, input logic exp);
        @(negedge clk);
        chk_valid = 1'b1; chk_hw = hw; chk_write = wr; chk_addr = a;
        @(negedge clk);
        chk_valid = 1'b0;
        expect_eq(tag, int'(chk_ok), int'(exp));
    endtask

    task automatic sw_pulse(input logic inc, input logic dec);
        @(negedge clk);
        sw_inc = inc; sw_dec = dec;
        @(negedge clk);
        sw_inc = 1'b0; sw_dec = 1'b0;
    endtask

    task automatic start_hw(input logic [1:0] id);
        @(negedge clk);
        hw_begin = 1'b1; hw_begin_id = id;
        @(negedge clk);
        hw_begin = 1'b0;
    endtask

    task automatic t_reset();
        expect_eq("reset rsp_valid R11", int'(rsp_valid), 0);
        expect_eq("reset chk_done R11", int'(chk_done), 0);
        expect_eq("reset hw_fail R10", int'(hw_fail), 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 16'h000A; req_tid = 4'd1;
        chk_valid = 1'b1; chk_write = 1'b0; chk_addr = 16'h000A;
        #1;
        expect_eq("rsp not before edge R11", int'(rsp_valid), 0);
        @(negedge clk);
        req_valid = 1'b0; chk_valid = 1'b0;
        expect_eq("rsp one cycle R11", int'(rsp_valid), 1);
        expect_eq("chk one cycle R11", int'(chk_done), 1);
        @(negedge clk);
        expect_eq("rsp single pulse R11", int'(rsp_valid), 0);
        req_exp("release latency rec R5", 2'd2, 16'h000A, 4'd1, 1'b1);
        req_exp("op none refused R5", 2'd3, 16'h000A, 4'd1, 1'b0);
    endtask

    task automatic t_read();
        req_exp("read free R2", 2'd0, 16'h0002, 4'd1, 1'b1);
        req_exp("read shared R2", 2'd0, 16'h0002, 4'd2, 1'b1);
        chk_exp("read check shared R7", 2'd0, 1'b0, 16'h0002, 1'b1);
        chk_exp("write check shared R7", 2'd0, 1'b1, 16'h0002, 1'b0);
        req_exp("release reader R5", 2'd2, 16'h0002, 4'd2, 1'b1);
        chk_exp("still shared R5", 2'd0, 1'b1, 16'h0002, 1'b0);
        req_exp("release last reader R5", 2'd2, 16'h0002, 4'd1, 1'b1);
        chk_exp("freed after last R5", 2'd0, 1'b1, 16'h0002, 1'b1);
        req_exp("release free refused R5", 2'd2, 16'h0002, 4'd1, 1'b0);
    endtask

    task automatic t_write();
        req_exp("write free R3", 2'd1, 16'h0003, 4'd3, 1'b1);
        req_exp("read on excl R2", 2'd0, 16'h0003, 4'd4, 1'b0);
        req_exp("write on excl R3", 2'd1, 16'h0003, 4'd4, 1'b0);
        chk_exp("read check excl R7", 2'd0, 1'b0, 16'h0003, 1'b0);
        req_exp("release wrong id R5", 2'd2, 16'h0003, 4'd4, 1'b0);
        chk_exp("excl kept R5", 2'd0, 1'b0, 16'h0003, 1'b0);
        req_exp("release owner R5", 2'd2, 16'h0003, 4'd3, 1'b1);
        chk_exp("freed by owner R5", 2'd0, 1'b1, 16'h0003, 1'b1);
    endtask

    task automatic t_upgrade();
        req_exp("read sole R4", 2'd0, 16'h0004, 4'd5, 1'b1);
        req_exp("upgrade sole R4", 2'd1, 16'h0004, 4'd5, 1'b1);
        chk_exp("upgraded excl R4", 2'd0, 1'b0, 16'h0004, 1'b0);
        req_exp("release upgraded R4", 2'd2, 16'h0004, 4'd5, 1'b1);
        req_exp("read first R4", 2'd0, 16'h0004, 4'd5, 1'b1);
        req_exp("read second R4", 2'd0, 16'h0004, 4'd6, 1'b1);
        req_exp("upgrade with two readers R3", 2'd1, 16'h0004, 4'd5, 1'b0);
        req_exp("upgrade by non first R4", 2'd1, 16'h0004, 4'd6, 1'b0);
        req_exp("second leaves R4", 2'd2, 16'h0004, 4'd6, 1'b1);
        req_exp("upgrade after leave R4", 2'd1, 16'h0004, 4'd5, 1'b1);
        req_exp("release R4", 2'd2, 16'h0004, 4'd5, 1'b1);
    endtask

    task automatic t_alias();
        expect_eq("bench fold R1", int'(fold(16'h1000)), int'(fold(16'h0040)));
        req_exp("write alias base R1", 2'd1, 16'h0001, 4'd7, 1'b1);
        req_exp("alias mid chunk R1", 2'd0, 16'h0040, 4'd8, 1'b0);
        req_exp("alias top chunk R1", 2'd0, 16'h1000, 4'd8, 1'b0);
        req_exp("distinct index R1", 2'd0, 16'h0002, 4'd8, 1'b1);
        req_exp("distinct release R1", 2'd2, 16'h0002, 4'd8, 1'b1);
        req_exp("release via alias R1", 2'd2, 16'h0040, 4'd7, 1'b1);
        req_exp("read after alias free R1", 2'd0, 16'h0001, 4'd8, 1'b1);
        req_exp("release R1", 2'd2, 16'h0001, 4'd8, 1'b1);
    endtask

    task automatic t_saturate();
        int grants = 0;
        logic g;
        for (int i = 0; i < 63; i++) begin
            do_req(2'd0, 16'h0005, 4'(i), g);
            grants += int'(g);
        end
        expect_eq("63 readers granted R6", grants, 63);
        req_exp("64th reader refused R6", 2'd0, 16'h0005, 4'd9, 1'b0);
        grants = 0;
        for (int i = 0; i < 63; i++) begin
            do_req(2'd2, 16'h0005, 4'd15, g);
            grants += int'(g);
        end
        expect_eq("63 releases granted R6", grants, 63);
        req_exp("free after saturation R6", 2'd1, 16'h0005, 4'd9, 1'b1);
        req_exp("release R6", 2'd2, 16'h0005, 4'd9, 1'b1);
    endtask

    task automatic t_watch();
        start_hw(2'd0);
        chk_exp("watch check free R7", 2'd0, 1'b0, 16'h0006, 1'b1);
        req_exp("read on watched R10", 2'd0, 16'h0006, 4'd1, 1'b1);
        expect_eq("spurious fail raised R10", int'(hw_fail[0]), 1);
        start_hw(2'd1);
        chk_exp("watch other R10", 2'd1, 1'b0, 16'h0007, 1'b1);
        req_exp("unwatched write R10", 2'd1, 16'h0008, 4'd2, 1'b1);
        expect_eq("unwatched no fail R10", int'(hw_fail[1]), 0);
        expect_eq("fail sticky R10", int'(hw_fail[0]), 1);
        start_hw(2'd0);
        expect_eq("begin clears fail R10", int'(hw_fail[0]), 0);
        req_exp("change after restart R10", 2'd2, 16'h0006, 4'd1, 1'b1);
        expect_eq("cleared mask R10", int'(hw_fail[0]), 0);
        req_exp("release R10", 2'd2, 16'h0008, 4'd2, 1'b1);
    endtask

    task automatic t_idle();
        sw_pulse(1'b0, 1'b1);
        req_exp("table works at zero R8", 2'd1, 16'h0009, 4'd2, 1'b1);
        chk_exp("idle pass R8", 2'd0, 1'b1, 16'h0009, 1'b1);
        start_hw(2'd2);
        chk_exp("idle check slot2 R8", 2'd2, 1'b0, 16'h0009, 1'b1);
        sw_pulse(1'b0, 1'b1);
        sw_pulse(1'b1, 1'b0);
        chk_exp("dec at zero held R9", 2'd0, 1'b1, 16'h0009, 1'b0);
        sw_pulse(1'b1, 1'b1);
        chk_exp("inc and dec hold R9", 2'd0, 1'b1, 16'h0009, 1'b0);
        req_exp("change unwatched at idle R8", 2'd2, 16'h0009, 4'd2, 1'b1);
        expect_eq("idle check not watched R8", int'(hw_fail[2]), 0);
        req_exp("write again R9", 2'd1, 16'h0009, 4'd2, 1'b1);
        sw_pulse(1'b0, 1'b1);
        chk_exp("back to zero R9", 2'd0, 1'b1, 16'h0009, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        sw_pulse(1'b1, 1'b0);
        t_read();
        t_write();
        t_upgrade();
        t_alias();
        t_saturate();
        t_watch();
        t_idle();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end
endmodule